// File: doc/BRIEF.md
# Strap-Addressed I2C Target Port

This block is the target side of a two-wire I2C control link. An external controller always owns the clock line and opens every transfer; the block only listens, answers with acknowledge bits and, during reads, places data bits on the data line. It never drives SCL. It drives SDA in open-drain fashion: it either pulls the line low or lets go of it. Both Standard-mode (100 kbit/s) and Fast-mode (400 kbit/s) bus rates are handled, because both lines are oversampled by a much faster system clock.

The 7-bit target address has a fixed five-bit upper part, `00111`. The two lowest bits come from a pair of board strap inputs, and each strap reads as 0 when tied low and 1 when tied high. Every byte the controller writes after a matching address is acknowledged and handed to the command logic with a one-cycle strobe. Bytes for a read are taken from the command logic with a one-cycle take strobe at the start of each byte. A repeated START is never treated as a new transfer. Once a transfer is open, a second START puts the port into a lockout in which it ignores the bus until a STOP.

The controller (FSM) has eight states. `S_IDLE` waits for a START. `S_ADDR` shifts in the address byte. `S_ADDR_ACK` holds the address acknowledge. `S_WR_BIT` and `S_WR_ACK` receive a written byte and acknowledge it. `S_RD_BIT` shifts out a read byte. `S_RD_ACK` samples the controller's acknowledge. `S_LOCKOUT` ignores the bus until a STOP. The transitions are:
- start-open: `S_IDLE` to `S_ADDR` on a START.
- addr-hit: `S_ADDR` to `S_ADDR_ACK` when the address matches.
- addr-miss: `S_ADDR` to `S_LOCKOUT` when it does not.
- ack-to-write and ack-to-read: `S_ADDR_ACK` to `S_WR_BIT` or to `S_RD_BIT`, chosen by the R/W bit.
- byte-in: `S_WR_BIT` to `S_WR_ACK`.
- ack-done: `S_WR_ACK` back to `S_WR_BIT`.
- byte-out: `S_RD_BIT` to `S_RD_ACK`.
- more: `S_RD_ACK` to `S_RD_BIT` when the controller acknowledges.
- read-end: `S_RD_ACK` to `S_LOCKOUT` when it does not.
- restart-reject: any state other than `S_IDLE` to `S_LOCKOUT` on a START.
- stop-close: any state to `S_IDLE` on a STOP.

Top module: `i2c_strap_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {0,0,1,1,1,addr_strap[1],addr_strap[0]}, MSB first. The eighth bit is R/W, with 0 meaning write and 1 meaning read. On a mismatch the block leaves SDA released until the next STOP.
- R2: After a write address, each byte is sampled MSB first on SCL rising edges. It is acknowledged, and after its eighth bit it is presented on wr_data with wr_valid high for exactly one system-clock cycle.
- R3: After a read address, the block samples rd_data with a one-cycle rd_take pulse at the start of each read byte, and shifts that byte out MSB first. A released line reads as 1.
- R4: When the controller acknowledges a read byte (SDA low on the ninth bit), the next byte is fetched and sent. When it does not acknowledge, the block releases SDA, makes no further rd_take pulse and sends only ones until the next STOP.
- R5: A START while a transfer is open is rejected. Until a STOP, the block gives no acknowledge and no wr_valid pulse, even for a matching address.
- R6: A STOP at any point, including in the middle of a byte, ends the transfer without presenting a partial byte, and the next START is accepted normally.
- R7: sda_drive_low changes only while SCL is low.
- R8: During reset, sda_drive_low, wr_valid and rd_take are all 0.
- R9: wr_valid and rd_take are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, far faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_strap | input | 2 | Strap pins for the two low address bits (bit 1 is the higher of the two) |
| wr_data | output | 8 | Last byte written by the controller |
| wr_valid | output | 1 | One-cycle strobe marking a new wr_data byte |
| rd_data | input | 8 | Byte to send on the next read byte |
| rd_take | output | 1 | One-cycle strobe marking the cycle rd_data is sampled |

## Verification
The checker watches the bus-side hygiene rules on every clock: the SDA driver moves only while SCL is low, both strobes are single-cycle and never coincide, and every output is quiet during reset. Address decoding across all strap settings, write and read data integrity, controller ACK/NACK handling, the rejection of a repeated START and the recovery after a STOP in the middle of a byte depend on whole bus sequences. Only the bench's scenarios can show those, by comparing acknowledge bits, captured bytes and strobe counts with values computed from the requirements.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 7;
    localparam int STRAP_W  = 2;
    localparam int PREFIX_W = ADDR_W - STRAP_W;
    localparam logic [PREFIX_W-1:0] DEV_PREFIX = 5'b00111;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_WR_BIT,
        S_WR_ACK,
        S_RD_BIT,
        S_RD_ACK,
        S_LOCKOUT
    } i2cs_state_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_cur,
    output logic [WIDTH-1:0] q_prev
);
    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= '1;
                    else        pipe[g] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= '1;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_prev <= '1;
        else        q_prev <= pipe[STAGES-1];
    end

    assign q_cur = pipe[STAGES-1];
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
    input  logic scl_cur,
    input  logic scl_prev,
    input  logic sda_cur,
    input  logic sda_prev,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);
    // SDA moving while SCL stays high marks the frame boundaries
    assign start_ev = scl_cur & scl_prev & sda_prev & ~sda_cur;
    assign stop_ev  = scl_cur & scl_prev & ~sda_prev & sda_cur;
    assign scl_rise = scl_cur & ~scl_prev;
    assign scl_fall = ~scl_cur & scl_prev;
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_drive_low,
    input  logic [1:0] addr_strap,
    output logic [7:0] wr_data,
    output logic       wr_valid,
    input  logic [7:0] rd_data,
    output logic       rd_take
);
    import i2cs_pkg::*;

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [1:0] line_raw, line_cur, line_prev;
    logic       start_ev, stop_ev, scl_rise, scl_fall;

    assign line_raw = {scl_i, sda_i};

    i2cs_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (line_raw),
        .q_cur  (line_cur),
        .q_prev (line_prev)
    );

    i2cs_bus_events u_events (
        .scl_cur  (line_cur[1]),
        .scl_prev (line_prev[1]),
        .sda_cur  (line_cur[0]),
        .sda_prev (line_prev[0]),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    i2cs_state_t       state, state_n;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sr, tx_sr;
    logic              rw_q, host_ack, addr_hit, byte_end;

    assign addr_hit = (rx_sr[BYTE_W-1:1] == {DEV_PREFIX, addr_strap});
    assign byte_end = scl_fall && (bit_cnt == FULL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        if (stop_ev) begin
            state_n = S_IDLE;
        end else if (start_ev) begin
            state_n = (state == S_IDLE) ? S_ADDR : S_LOCKOUT;
        end else begin
            unique case (state)
                S_IDLE, S_LOCKOUT: state_n = state;
                S_ADDR:     if (byte_end) state_n = addr_hit ? S_ADDR_ACK : S_LOCKOUT;
                S_ADDR_ACK: if (scl_fall) state_n = rw_q ? S_RD_BIT : S_WR_BIT;
                S_WR_BIT:   if (byte_end) state_n = S_WR_ACK;
                S_WR_ACK:   if (scl_fall) state_n = S_WR_BIT;
                S_RD_BIT:   if (byte_end) state_n = S_RD_ACK;
                S_RD_ACK:   if (scl_fall) state_n = host_ack ? S_RD_BIT : S_LOCKOUT;
                default:    state_n = S_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt       <= '0;
            rx_sr         <= '0;
            tx_sr         <= '0;
            rw_q          <= 1'b0;
            host_ack      <= 1'b0;
            sda_drive_low <= 1'b0;
            wr_data       <= '0;
            wr_valid      <= 1'b0;
            rd_take       <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            rd_take  <= 1'b0;
            if (stop_ev || start_ev) begin
                bit_cnt       <= '0;
                sda_drive_low <= 1'b0;
            end else begin
                unique case (state)
                    S_IDLE, S_LOCKOUT: begin
                        sda_drive_low <= 1'b0;
                    end
                    S_ADDR, S_WR_BIT: begin
                        if (scl_rise) begin
                            rx_sr   <= {rx_sr[BYTE_W-2:0], line_cur[0]};
                            bit_cnt <= bit_cnt + ONE;
                        end else if (byte_end) begin
                            bit_cnt <= '0;
                            if (state == S_ADDR) begin
                                sda_drive_low <= addr_hit;
                                rw_q          <= rx_sr[0];
                            end else begin
                                wr_data       <= rx_sr;
                                wr_valid      <= 1'b1;
                                sda_drive_low <= 1'b1;
                            end
                        end
                    end
                    S_ADDR_ACK, S_RD_ACK: begin
                        if (scl_rise && state == S_RD_ACK) begin
                            host_ack <= ~line_cur[0];
                        end else if (scl_fall) begin
                            if ((state == S_ADDR_ACK) ? rw_q : host_ack) begin
                                tx_sr         <= rd_data;
                                rd_take       <= 1'b1;
                                sda_drive_low <= ~rd_data[BYTE_W-1];
                                bit_cnt       <= ONE;
                            end else begin
                                sda_drive_low <= 1'b0;
                                bit_cnt       <= '0;
                            end
                        end
                    end
                    S_WR_ACK: begin
                        if (scl_fall) begin
                            sda_drive_low <= 1'b0;
                            bit_cnt       <= '0;
                        end
                    end
                    S_RD_BIT: begin
                        if (byte_end) begin
                            sda_drive_low <= 1'b0;
                        end else if (scl_fall) begin
                            tx_sr         <= tx_sr << 1;
                            sda_drive_low <= ~tx_sr[BYTE_W-2];
                            bit_cnt       <= bit_cnt + ONE;
                        end
                    end
                    default: sda_drive_low <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_strap_slave_chk.sv
module i2c_strap_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_drive_low,
    input logic wr_valid,
    input logic rd_take
);
    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!sda_drive_low && !wr_valid && !rd_take));

    // R2
    wr_strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R3
    rd_strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |=> !rd_take);

    // R9
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && rd_take));

    // R7
    sda_move_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low)) |-> !scl_i);
endmodule

bind i2c_strap_slave i2c_strap_slave_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_i),
    .sda_drive_low (sda_drive_low),
    .wr_valid      (wr_valid),
    .rd_take       (rd_take)
);

// File: tb/i2c_strap_slave_test.sv
module i2c_strap_slave_test;
    localparam int Q = 12;

    typedef struct packed {
        logic [1:0] strap;
        logic [6:0] addr;
        logic       rw;
        logic [7:0] data;
        logic       ack;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{2'b00, 7'h1C, 1'b0, 8'hA5, 1'b1},
        '{2'b01, 7'h1D, 1'b0, 8'h3C, 1'b1},
        '{2'b10, 7'h1E, 1'b0, 8'h00, 1'b1},
        '{2'b11, 7'h1F, 1'b0, 8'hFF, 1'b1},
        '{2'b11, 7'h1C, 1'b0, 8'h55, 1'b0},
        '{2'b00, 7'h5C, 1'b0, 8'h12, 1'b0},
        '{2'b10, 7'h1E, 1'b1, 8'hC3, 1'b1},
        '{2'b01, 7'h1D, 1'b1, 8'h81, 1'b1},
        '{2'b00, 7'h1D, 1'b1, 8'h7E, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_drive_low;
    logic [1:0] addr_strap = 2'b00;
    logic [7:0] wr_data;
    logic       wr_valid;
    logic [7:0] rd_data = 8'h00;
    logic       rd_take;

    int n_chk = 0, n_bad = 0, rx_cnt = 0, take_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    bit done = 1'b0;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_drive_low;

    i2c_strap_slave uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_m),
        .sda_i         (sda_line),
        .sda_drive_low (sda_drive_low),
        .addr_strap    (addr_strap),
        .wr_data       (wr_data),
        .wr_valid      (wr_valid),
        .rd_data       (rd_data),
        .rd_take       (rd_take)
    );

    always @(negedge clk) begin
        if (wr_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= wr_data;
        end
        if (rd_take) take_cnt <= take_cnt + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic get_bits(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic       a;
        logic [7:0] g;
        int         rx0, tk0;

        tick(4);
        // R8: quiet outputs while reset is held
        check("R8 drive", sda_drive_low, 0);
        check("R8 wr_valid", wr_valid, 0);
        check("R8 rd_take", rd_take, 0);
        rst_n = 1'b1;
        tick(10);
        check("R8 idle after reset", sda_drive_low, 0);

        // Table walk: R1 address decode, R2 write, R3 read
        foreach (VECS[k]) begin
            addr_strap = VECS[k].strap;
            rd_data    = VECS[k].data;
            tick(Q);
            rx0 = rx_cnt;
            tk0 = take_cnt;
            bus_start();
            send_byte({VECS[k].addr, VECS[k].rw}, a);
            check("R1 address ack", a, VECS[k].ack);
            if (!VECS[k].rw) begin
                send_byte(VECS[k].data, a);
                if (VECS[k].ack) begin
                    check("R2 data ack", a, 1);
                    check("R2 one strobe", rx_cnt - rx0, 1);
                    check("R2 data value", rx_last, VECS[k].data);
                end else begin
                    check("R1 lockout no ack", a, 0);
                    check("R1 lockout no strobe", rx_cnt - rx0, 0);
                end
            end else begin
                get_bits(g);
                put_bit(1'b1);
                if (VECS[k].ack) begin
                    check("R3 read value", g, VECS[k].data);
                    check("R3 one take", take_cnt - tk0, 1);
                end else begin
                    check("R1 miss reads ones", g, 8'hFF);
                    check("R1 miss no take", take_cnt - tk0, 0);
                end
            end
            bus_stop();
        end

        // R5: repeated START after an accepted write
        addr_strap = 2'b00;
        rx0 = rx_cnt;
        bus_start();
        send_byte(8'h38, a);
        send_byte(8'h11, a);
        check("R2 first byte ack", a, 1);
        bus_start();
        send_byte(8'h38, a);
        check("R5 restart addr nack", a, 0);
        send_byte(8'h22, a);
        check("R5 restart data nack", a, 0);
        check("R5 strobe count", rx_cnt - rx0, 1);
        check("R5 last byte kept", rx_last, 8'h11);
        bus_stop();
        // R6: normal after STOP
        bus_start();
        send_byte(8'h38, a);
        check("R6 addr ack after stop", a, 1);
        send_byte(8'h44, a);
        check("R6 data after stop", rx_last, 8'h44);
        bus_stop();

        // R5: address miss then a START without STOP stays locked
        bus_start();
        send_byte(8'h3A, a);
        check("R1 strap miss", a, 0);
        bus_start();
        send_byte(8'h38, a);
        check("R5 locked until stop", a, 0);
        bus_stop();

        // R4: two-byte read with controller ACK, then NACK
        rd_data = 8'h96;
        tk0 = take_cnt;
        bus_start();
        send_byte(8'h39, a);
        check("R1 read addr ack", a, 1);
        get_bits(g);
        check("R4 first byte", g, 8'h96);
        rd_data = 8'h5A;
        put_bit(1'b0);
        get_bits(g);
        check("R4 second byte", g, 8'h5A);
        put_bit(1'b1);
        get_bits(g);
        check("R4 after nack ones", g, 8'hFF);
        check("R4 take count", take_cnt - tk0, 2);
        bus_stop();

        // R6: STOP in the middle of a byte
        rx0 = rx_cnt;
        bus_start();
        send_byte(8'h38, a);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_stop();
        check("R6 no partial byte", rx_cnt - rx0, 0);
        bus_start();
        send_byte(8'h38, a);
        check("R6 addr after abort", a, 1);
        send_byte(8'h77, a);
        check("R6 data after abort", rx_last, 8'h77);
        check("R6 count after abort", rx_cnt - rx0, 1);
        bus_stop();
        check("R7 released at end", sda_drive_low, 0);

        finish_run();
    end
endmodule